// File: doc/BRIEF.md
# Variable-Rate Sample Block Cadence Generator

The block works out, once per fixed 48 kHz link frame, how many sample blocks a single stream carries in that frame. A base-rate select picks between the 48 kHz family and the 44.1 kHz family. A multiplier and a divisor scale the base rate, so the delivered rate is base × mult / div. Each stream that needs its own cadence gets its own instance.

The cadence comes from one remainder accumulator. For each frame it adds a step of `mult` (48 kHz family) or `147*mult` (44.1 kHz family). It emits one block for each whole modulus of `div` or `160*div` that the running sum holds, and keeps the remainder. After any clear, the accumulator starts one below the modulus. The first frame therefore always carries a block, and each repeating pattern starts with its fullest frame. A clear happens on reset, on a change of setting, and while the setting is invalid.

Top module: `cadence_gen`

## Requirements
- R1: A strobe on `frame_i` in one clock cycle produces a one-cycle pulse on `blk_vld_o` in the next cycle, together with the new count on `blk_cnt_o`. `blk_vld_o` is low in every other cycle.
- R2: While `rst_ni` is low, and after it is released until the first frame, `blk_cnt_o` is 0 and `blk_vld_o` is 0.
- R3: With `base_sel_i`=0 (48 kHz family), `div_i`=1 and `mult_i`=n with n in 1..4, every frame carries exactly n blocks.
- R4: With `base_sel_i`=0, `mult_i`=1 and `div_i`=n>1, the first frame after a clear carries 1 block and the following n-1 frames carry 0. The pattern then repeats.
- R5: With `base_sel_i`=1 (44.1 kHz family), every run of 160×div frames that starts at a clear carries exactly 147×mult blocks. With div=1, each frame carries either mult or mult-1 blocks.
- R6: In the 44.1 kHz family, the count of frame k after a clear (k counted from 1) is floor((M-1+k·S)/M) − floor((M-1+(k-1)·S)/M), where S=147·mult and M=160·div. The first frame therefore carries ceil(S/M) blocks.
- R7: If both mult>1 and div>1, the rate is mult/div of the base. In the 48 kHz family, every run of div frames after a clear carries mult blocks, and the counts follow the formula of R6 with S=mult and M=div.
- R8: A change of any of `base_sel_i`, `mult_i` or `div_i` between frames clears the accumulator, so the next frame is the first frame of the new setting.
- R9: A setting with `mult_i`=0, `mult_i`>4 or `div_i`=0 is invalid. Each frame under it reports 0 blocks, and a valid setting that follows it starts from a clear.
- R10: `blk_cnt_o` changes only in the cycle where `blk_vld_o` is high, and holds its value between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe at the start of each 48 kHz frame |
| base_sel_i | input | 1 | 0 selects the 48 kHz family, 1 selects the 44.1 kHz family |
| mult_i | input | MULT_W (3) | Rate multiplier, valid 1..4 |
| div_i | input | DIV_W (4) | Rate divisor, valid 1..15 |
| blk_cnt_o | output | CNT_W (3) | Blocks to carry in the current frame, 0..4 |
| blk_vld_o | output | 1 | Pulses high for one cycle when a new count is presented |

## Verification
A wrong remainder stays in the accumulator rather than showing up at once. It may show as a single frame whose count is one too high or too low, and that frame can come up to a whole 160×div frame window later. For this reason the bench compares every frame against the closed-form count, and also sums each full window. A missed clear on a change of setting shows on the very first frame of the new setting. The setting-change test is chosen so that a stale remainder gives 0 where 1 is expected.

// File: rtl/cadence_pkg.sv
package cadence_pkg;
  localparam int unsigned FAM44_NUM = 147;  // blocks per window in the 44.1 kHz family
  localparam int unsigned FAM44_DEN = 160;  // frames per window

  typedef enum logic {
    BASE_48K = 1'b0,
    BASE_44K = 1'b1
  } base_e;
endpackage

// File: rtl/cadence_rate.sv
module cadence_rate
  import cadence_pkg::*;
#(
  parameter int MULT_W  = 3,
  parameter int DIV_W   = 4,
  parameter int MAX_BLK = 4,
  parameter int W       = 14
) (
  input  logic              base_sel_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [W-1:0]      step_o,
  output logic [W-1:0]      modulus_o,
  output logic              valid_o
);
  always_comb begin
    if (base_e'(base_sel_i) == BASE_44K) begin
      step_o    = W'(mult_i) * W'(FAM44_NUM);
      modulus_o = W'(div_i) * W'(FAM44_DEN);
    end else begin
      step_o    = W'(mult_i);
      modulus_o = W'(div_i);
    end
    valid_o = (mult_i != '0) && (mult_i <= MULT_W'(MAX_BLK)) && (div_i != '0);
  end
endmodule

// File: rtl/cadence_divide.sv
module cadence_divide #(
  parameter int MAX_BLK = 4,
  parameter int CNT_W   = 3,
  parameter int W       = 14
) (
  input  logic [W-1:0]     sum_i,
  input  logic [W-1:0]     modulus_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [W-1:0]     rem_o
);
  logic [MAX_BLK-1:0] reach;

  // one comparator per possible block
  for (genvar k = 0; k < MAX_BLK; k++) begin : g_cmp
    logic [W-1:0] lim;
    assign lim      = W'(k + 1) * modulus_i;
    assign reach[k] = (sum_i >= lim);
  end

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < MAX_BLK; i++) cnt_o = cnt_o + CNT_W'(reach[i]);
    rem_o = sum_i - W'(cnt_o) * modulus_i;
  end
endmodule

// File: rtl/cadence_gen.sv
module cadence_gen
  import cadence_pkg::*;
#(
  parameter int MULT_W  = 3,
  parameter int DIV_W   = 4,
  parameter int MAX_BLK = 4,
  localparam int CNT_W  = $clog2(MAX_BLK + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              base_sel_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [CNT_W-1:0]  blk_cnt_o,
  output logic              blk_vld_o
);
  localparam int W = $clog2(MAX_BLK * FAM44_DEN * (2 ** DIV_W) + 1);

  typedef struct packed {
    logic              base;
    logic [MULT_W-1:0] mult;
    logic [DIV_W-1:0]  div;
  } cfg_t;

  cfg_t             cfg_now, cfg_q;
  logic             fresh_q, chg, valid;
  logic [W-1:0]     acc_q, acc_eff, step, modulus, sum, rem;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             vld_q;

  assign cfg_now = '{base: base_sel_i, mult: mult_i, div: div_i};
  assign chg     = (cfg_now != cfg_q);

  cadence_rate #(
    .MULT_W(MULT_W), .DIV_W(DIV_W), .MAX_BLK(MAX_BLK), .W(W)
  ) u_rate (
    .base_sel_i(base_sel_i),
    .mult_i    (mult_i),
    .div_i     (div_i),
    .step_o    (step),
    .modulus_o (modulus),
    .valid_o   (valid)
  );

  // after a clear, start one below the modulus so frame 1 carries a block
  assign acc_eff = (fresh_q || chg) ? (modulus - W'(1)) : acc_q;
  assign sum     = acc_eff + step;

  cadence_divide #(
    .MAX_BLK(MAX_BLK), .CNT_W(CNT_W), .W(W)
  ) u_div (
    .sum_i    (sum),
    .modulus_i(modulus),
    .cnt_o    (cnt_d),
    .rem_o    (rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      fresh_q <= 1'b1;
      acc_q   <= '0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      cfg_q <= cfg_now;
      vld_q <= frame_i;
      if (frame_i) begin
        if (valid) begin
          cnt_q   <= cnt_d;
          acc_q   <= rem;
          fresh_q <= 1'b0;
        end else begin
          cnt_q   <= '0;
          fresh_q <= 1'b1;
        end
      end else if (chg) begin
        fresh_q <= 1'b1;
      end
    end
  end

  assign blk_cnt_o = cnt_q;
  assign blk_vld_o = vld_q;
endmodule

// File: rtl/cadence_gen_chk.sv
module cadence_gen_chk #(
  parameter int MULT_W  = 3,
  parameter int DIV_W   = 4,
  parameter int MAX_BLK = 4,
  parameter int CNT_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_i,
  input logic              base_sel_i,
  input logic [MULT_W-1:0] mult_i,
  input logic [DIV_W-1:0]  div_i,
  input logic [CNT_W-1:0]  blk_cnt_o,
  input logic              blk_vld_o
);
  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(blk_cnt_o) <= MAX_BLK);

  p_vld_after_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> blk_vld_o);

  p_hold_between_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_vld_o |-> $stable(blk_cnt_o));

  p_int_mult_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_vld_o && $past(!base_sel_i && int'(div_i) == 1 && int'(mult_i) >= 1
                        && int'(mult_i) <= MAX_BLK))
    |-> int'(blk_cnt_o) == int'($past(mult_i)));

  p_sub_mult_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_vld_o && $past(!base_sel_i && int'(mult_i) == 1 && int'(div_i) > 1))
    |-> int'(blk_cnt_o) <= 1);

  p_fam44_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_vld_o && $past(base_sel_i && int'(div_i) == 1 && int'(mult_i) >= 1
                        && int'(mult_i) <= MAX_BLK))
    |-> (int'(blk_cnt_o) <= int'($past(mult_i)))
        && (int'(blk_cnt_o) + 1 >= int'($past(mult_i))));

  p_invalid_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_vld_o && $past(int'(mult_i) == 0 || int'(mult_i) > MAX_BLK
                        || int'(div_i) == 0))
    |-> blk_cnt_o == '0);
endmodule

bind cadence_gen cadence_gen_chk #(
  .MULT_W(MULT_W), .DIV_W(DIV_W), .MAX_BLK(MAX_BLK), .CNT_W(CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frame_i   (frame_i),
  .base_sel_i(base_sel_i),
  .mult_i    (mult_i),
  .div_i     (div_i),
  .blk_cnt_o (blk_cnt_o),
  .blk_vld_o (blk_vld_o)
);

// File: tb/sim_cadence_gen.sv
`timescale 1ns/1ps
module sim_cadence_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0;
  logic       base_sel_i = 1'b0;
  logic [2:0] mult_i = 3'd1;
  logic [3:0] div_i = 4'd1;
  logic [2:0] blk_cnt_o;
  logic       blk_vld_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  cadence_gen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .base_sel_i(base_sel_i),
    .mult_i(mult_i), .div_i(div_i), .blk_cnt_o(blk_cnt_o), .blk_vld_o(blk_vld_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // closed-form count for frame k after a clear
  function automatic int exp_cnt(input int s, input int m, input int k);
    return (m - 1 + k * s) / m - (m - 1 + (k - 1) * s) / m;
  endfunction

  task automatic do_frame(output int c);
    @(negedge clk_i) frame_i = 1'b1;
    @(negedge clk_i) frame_i = 1'b0;
    c = int'(blk_cnt_o);
    chk(blk_vld_o == 1'b1, "R1 vld after frame", int'(blk_vld_o), 1);
    @(negedge clk_i);
    chk(blk_vld_o == 1'b0, "R1 vld one cycle", int'(blk_vld_o), 0);
    chk(int'(blk_cnt_o) == c, "R10 count held", int'(blk_cnt_o), c);
  endtask

  task automatic set_cfg(input bit b, input int m, input int d);
    @(negedge clk_i) mult_i = 3'd0;  // invalid in between forces a clear (R9)
    @(negedge clk_i) begin base_sel_i = b; mult_i = 3'(m); div_i = 4'(d); end
  endtask

  task automatic run_win(input bit b, input int m, input int d, input int n,
                         input int exp_sum, input string req);
    int s, md, c, sum, bad, first;
    s   = b ? 147 * m : m;
    md  = b ? 160 * d : d;
    sum = 0; bad = 0; first = 0;
    set_cfg(b, m, d);
    for (int k = 1; k <= n; k++) begin
      do_frame(c);
      if (k == 1) first = c;
      sum += c;
      if (c != exp_cnt(s, md, k)) begin
        bad++;
        $display("FAIL %s frame %0d: actual %0d expected %0d", req, k, c, exp_cnt(s, md, k));
      end
    end
    chk(bad == 0, req, bad, 0);
    chk(sum == exp_sum, req, sum, exp_sum);
    if (b) chk(first == (s + md - 1) / md, "R6 first frame", first, (s + md - 1) / md);
  endtask

  task automatic t_reset();
    chk(blk_cnt_o == 3'd0, "R2 cnt in reset", int'(blk_cnt_o), 0);
    chk(blk_vld_o == 1'b0, "R2 vld in reset", int'(blk_vld_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(blk_cnt_o == 3'd0, "R2 cnt after reset", int'(blk_cnt_o), 0);
    chk(blk_vld_o == 1'b0, "R2 vld after reset", int'(blk_vld_o), 0);
  endtask

  task automatic t_mult48();
    for (int m = 1; m <= 4; m++) run_win(1'b0, m, 1, 8, 8 * m, "R3 integer multiple");
  endtask

  task automatic t_sub48();
    run_win(1'b0, 1, 2, 6, 3, "R4 sub-multiple /2");
    run_win(1'b0, 1, 3, 9, 3, "R4 sub-multiple /3");
    run_win(1'b0, 1, 5, 15, 3, "R4 sub-multiple /5");
  endtask

  task automatic t_fam44();
    run_win(1'b1, 1, 1, 160, 147, "R5 44.1k x1");
    run_win(1'b1, 2, 1, 160, 294, "R5 44.1k x2");
    run_win(1'b1, 4, 1, 320, 1176, "R5 44.1k x4");
    run_win(1'b1, 1, 2, 320, 147, "R5 44.1k /2");
    run_win(1'b1, 1, 4, 640, 147, "R5 44.1k /4");
  endtask

  task automatic t_mixed();
    run_win(1'b0, 3, 2, 8, 12, "R7 48k x3/2");
    run_win(1'b1, 3, 2, 320, 441, "R7 44.1k x3/2");
  endtask

  task automatic t_change();
    int c;
    set_cfg(1'b0, 1, 4);
    do_frame(c);
    chk(c == 1, "R8 first of /4", c, 1);
    @(negedge clk_i) div_i = 4'd3;  // direct change, no invalid step
    do_frame(c);
    chk(c == 1, "R8 cleared on change", c, 1);
    do_frame(c);
    chk(c == 0, "R8 /3 second", c, 0);
    do_frame(c);
    chk(c == 0, "R8 /3 third", c, 0);
    do_frame(c);
    chk(c == 1, "R8 /3 repeat", c, 1);
  endtask

  task automatic t_invalid();
    int c;
    set_cfg(1'b0, 4, 1);
    do_frame(c);
    chk(c == 4, "R9 valid before", c, 4);
    @(negedge clk_i) mult_i = 3'd0;
    do_frame(c);
    chk(c == 0, "R9 mult zero", c, 0);
    @(negedge clk_i) mult_i = 3'd5;
    do_frame(c);
    chk(c == 0, "R9 mult above max", c, 0);
    @(negedge clk_i) begin mult_i = 3'd1; div_i = 4'd0; end
    do_frame(c);
    chk(c == 0, "R9 div zero", c, 0);
    @(negedge clk_i) begin base_sel_i = 1'b1; div_i = 4'd1; end
    do_frame(c);
    chk(c == 1, "R9 fresh start after invalid", c, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    t_reset();
    t_mult48();
    t_sub48();
    t_fam44();
    t_mixed();
    t_change();
    t_invalid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule